// File: doc/BRIEF.md
# Flash Data Polling Status Generator

This block sits on the read path of an embedded flash array and replaces bit 7 of the read data while an automatic program or erase algorithm is running. A host polls any address and watches bit 7. While work is in progress the bit holds a status value. Once the work has finished, the bit is the true array bit again, so software can tell that the algorithm has terminated.

The block follows the operation in one registered state machine with these states: idle, programming, sector erase wait, erasing, erase suspended, program failed and erase failed. When a program starts, the block latches bit 7 of the byte being written. When a sector erase starts, it latches the upper address bits as the index of the target sector. Each read is judged from the state, from whether the address falls in that sector and from the latched bit. Bits 6 to 0 always come straight from the array. The algorithms and the array are modelled outside the block as strobes and data.

Top module: `fpoll_status`

## Requirements
- R1: After reset the block is idle and `rd_data` equals `arr_data` at every address.
- R2: A `prog_start` pulse in idle latches `wr_d7` and enters programming. While programming, `rd_data[7]` is the inverse of the latched bit at every address.
- R3: A program that finishes with `op_done` returns to idle. Reads then give the array's bit 7.
- R4: A `sec_erase_req` pulse in idle latches the sector index `addr[ADDR_W-1:SECT_W]` and enters the erase wait. An `erase_go` pulse then starts the erase. In both phases `rd_data[7]` is 0 at every address.
- R5: A `chip_erase_req` pulse in idle goes straight to erasing. `rd_data[7]` is 0 at every address, and `susp_req` has no effect.
- R6: An erase that finishes with `op_done` returns to idle. Reads then give the array's bit 7, which is 1 for an erased location.
- R7: `susp_req` during a sector erase enters suspend. While suspended, reads in the target sector give 1 on bit 7, and reads of other sectors give the array bit 7. `resume_req` returns to erasing, and target reads give 0 again.
- R8: `op_fail` while programming holds `rd_data[7]` at the inverse of the written bit. `op_fail` in erase wait or erasing holds it at 0. A failed state ignores every strobe except `clr`, which returns the block to idle.
- R9: `rd_data[6:0]` always equals `arr_data[6:0]`.
- R10: When strobes meet in the same cycle, `op_fail` wins over `op_done`, and `op_done` wins over `susp_req`. In idle, `prog_start` wins over the erase requests. Start strobes have no effect while an operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Returns a failed state to idle |
| prog_start | input | 1 | Program algorithm start pulse |
| wr_d7 | input | 1 | Bit 7 of the byte being programmed |
| sec_erase_req | input | 1 | Sector erase command pulse (sector taken from addr) |
| chip_erase_req | input | 1 | Chip erase command pulse |
| erase_go | input | 1 | End of the sector erase wait phase |
| op_done | input | 1 | Algorithm completed pulse |
| op_fail | input | 1 | Algorithm failed pulse |
| susp_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| addr | input | ADDR_W | Read and command address |
| arr_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data with the status bit 7 |

## Verification
Completion and suspend can meet in one cycle during a sector erase. Failure and completion can meet in one cycle during an erase or a program. The bench raises `op_done` together with `susp_req` while the erase is running. It then judges the result by reading the target sector with erased array data: bit 7 must read 1, and a further read with other data must pass through, which shows that the block went to idle and not to suspend. A second case raises `op_fail` together with `op_done`. Bit 7 must stay 0, and a suspend request must have no effect until `clr`.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PROG   = 3'd1,
    ST_EWAIT  = 3'd2,
    ST_ERASE  = 3'd3,
    ST_ESUSP  = 3'd4,
    ST_FAILP  = 3'd5,
    ST_FAILE  = 3'd6
  } fpoll_st_e;
endpackage

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
  import fpoll_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 13,
  localparam int IDX_W = ADDR_W - SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              prog_start,
  input  logic              wr_d7,
  input  logic              sec_erase_req,
  input  logic              chip_erase_req,
  input  logic              erase_go,
  input  logic              op_done,
  input  logic              op_fail,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic [IDX_W-1:0]  cmd_idx,
  output fpoll_st_e         st,
  output logic              prog_b7,
  output logic [IDX_W-1:0]  sect_q,
  output logic              chip_q
);
  fpoll_st_e st_nx;
  logic      en_prog, en_erase;

  assign en_prog  = (st == ST_IDLE) && prog_start;
  assign en_erase = (st == ST_IDLE) && !prog_start && (sec_erase_req || chip_erase_req);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: begin
        if (prog_start)          st_nx = ST_PROG;
        else if (sec_erase_req)  st_nx = ST_EWAIT;
        else if (chip_erase_req) st_nx = ST_ERASE;
      end
      ST_PROG: begin
        if (op_fail)      st_nx = ST_FAILP;
        else if (op_done) st_nx = ST_IDLE;
      end
      ST_EWAIT: begin
        if (op_fail)       st_nx = ST_FAILE;
        else if (erase_go) st_nx = ST_ERASE;
      end
      ST_ERASE: begin
        if (op_fail)                 st_nx = ST_FAILE;
        else if (op_done)            st_nx = ST_IDLE;
        else if (susp_req && !chip_q) st_nx = ST_ESUSP;
      end
      ST_ESUSP: begin
        if (resume_req) st_nx = ST_ERASE;
      end
      ST_FAILP, ST_FAILE: begin
        if (clr) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prog_b7 <= 1'b0;
    else if (en_prog) prog_b7 <= wr_d7;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q <= '0;
      chip_q <= 1'b0;
    end else if (en_erase) begin
      sect_q <= cmd_idx;
      chip_q <= !sec_erase_req;
    end
  end

  // R8: a failed state stays put until clr
  p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_FAILP) || (st == ST_FAILE)) && !clr |=> st == $past(st));

  // R5: a chip erase never reaches suspend
  p_chip_nosusp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ESUSP) |-> !chip_q);

  // R10: done beats suspend in the same cycle
  p_done_over_susp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE) && op_done && !op_fail |=> st == ST_IDLE);

  // R10: the sector index is frozen while an operation runs
  p_idx_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(sect_q));
endmodule

// File: rtl/fpoll_match.sv
module fpoll_match #(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 13,
  localparam int IDX_W = ADDR_W - SECT_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  sect_q,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  assign idx = addr[ADDR_W-1:SECT_W];
  assign hit = (idx == sect_q);
endmodule

// File: rtl/fpoll_mux.sv
module fpoll_mux
  import fpoll_pkg::*;
(
  input  fpoll_st_e   st,
  input  logic        prog_b7,
  input  logic        hit,
  input  logic [7:0]  arr_data,
  output logic [7:0]  rd_data
);
  logic b7;

  always_comb begin
    case (st)
      ST_PROG, ST_FAILP:           b7 = !prog_b7;
      ST_EWAIT, ST_ERASE, ST_FAILE: b7 = 1'b0;
      ST_ESUSP:                    b7 = hit ? 1'b1 : arr_data[7];
      default:                     b7 = arr_data[7];
    endcase
  end

  assign rd_data = {b7, arr_data[6:0]};

  // R9: lower bits are never touched
  always_comb begin
    a_low_pass_r9: assert (rd_data[6:0] == arr_data[6:0]);
  end
endmodule

// File: rtl/fpoll_status.sv
module fpoll_status
  import fpoll_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              prog_start,
  input  logic              wr_d7,
  input  logic              sec_erase_req,
  input  logic              chip_erase_req,
  input  logic              erase_go,
  input  logic              op_done,
  input  logic              op_fail,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        arr_data,
  output logic [7:0]        rd_data
);
  localparam int IDX_W = ADDR_W - SECT_W;

  fpoll_st_e        st;
  logic             prog_b7, chip_q, hit;
  logic [IDX_W-1:0] sect_q, idx;

  fpoll_match #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_match (
    .addr(addr), .sect_q(sect_q), .idx(idx), .hit(hit)
  );

  fpoll_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .prog_start(prog_start), .wr_d7(wr_d7),
    .sec_erase_req(sec_erase_req), .chip_erase_req(chip_erase_req),
    .erase_go(erase_go), .op_done(op_done), .op_fail(op_fail),
    .susp_req(susp_req), .resume_req(resume_req), .cmd_idx(idx),
    .st(st), .prog_b7(prog_b7), .sect_q(sect_q), .chip_q(chip_q)
  );

  fpoll_mux u_mux (
    .st(st), .prog_b7(prog_b7), .hit(hit), .arr_data(arr_data), .rd_data(rd_data)
  );

  // R2: first cycle of a program shows the inverse of the written bit
  p_prog_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == ST_IDLE) && $past(prog_start) |-> rd_data[7] == !$past(wr_d7));

  // R5: chip erase reads 0 everywhere
  p_chip_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE) && chip_q |-> !rd_data[7]);
endmodule

// File: tb/sim_fpoll_status.sv
module sim_fpoll_status;
  localparam int ADDR_W = 17;
  localparam int SECT_W = 13;

  logic clk = 1'b0;
  logic rst_n, clr, prog_start, wr_d7, sec_erase_req, chip_erase_req;
  logic erase_go, op_done, op_fail, susp_req, resume_req;
  logic [ADDR_W-1:0] addr;
  logic [7:0] arr_data, rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  fpoll_status #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .prog_start(prog_start), .wr_d7(wr_d7),
    .sec_erase_req(sec_erase_req), .chip_erase_req(chip_erase_req),
    .erase_go(erase_go), .op_done(op_done), .op_fail(op_fail),
    .susp_req(susp_req), .resume_req(resume_req), .addr(addr),
    .arr_data(arr_data), .rd_data(rd_data)
  );

  // monitor: compare once per cycle, mid-period
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        failures++;
        $display("FAIL %s: rd_data=%h expected=%h", it.tag, rd_data, it.exp);
      end
    end
  end

  function automatic logic [ADDR_W-1:0] sa(int s, int off);
    return ADDR_W'((s << SECT_W) + off);
  endfunction

  task automatic idle_in();
    clr = 0; prog_start = 0; sec_erase_req = 0; chip_erase_req = 0;
    erase_go = 0; op_done = 0; op_fail = 0; susp_req = 0; resume_req = 0;
  endtask

  // one-cycle strobe set: caller sets signals, this holds them across an edge
  task automatic pulse();
    @(posedge clk); #1;
    idle_in();
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [7:0] d, logic [7:0] e, string tag);
    addr = a; arr_data = d;
    sb.push_back('{exp: e, tag: tag});
    @(posedge clk); #1;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_in(); wr_d7 = 0; addr = '0; arr_data = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    rd(sa(0, 5), 8'hA5, 8'hA5, "R1 reset pass");
    rd(sa(7, 9), 8'h3C, 8'h3C, "R1 reset pass other");

    // program with written bit 7 = 1
    wr_d7 = 1; prog_start = 1; pulse();
    rd(sa(2, 0), 8'hFF, 8'h7F, "R2 prog inverse");
    rd(sa(9, 1), 8'h80, 8'h00, "R2 prog any address");
    rd(sa(1, 3), 8'h2B, 8'h2B, "R9 low bits in prog");
    wr_d7 = 0; prog_start = 1; pulse();
    rd(sa(2, 0), 8'hFF, 8'h7F, "R10 start ignored while busy");
    op_done = 1; pulse();
    rd(sa(2, 0), 8'h80, 8'h80, "R3 after program");
    rd(sa(2, 0), 8'h11, 8'h11, "R3 after program bit0");

    // program with written bit 7 = 0
    wr_d7 = 0; prog_start = 1; pulse();
    rd(sa(4, 4), 8'h00, 8'h80, "R2 prog inverse of 0");
    op_done = 1; pulse();

    // prog beats erase request in idle
    wr_d7 = 1; prog_start = 1; sec_erase_req = 1; addr = sa(6, 0); pulse();
    rd(sa(6, 0), 8'hFF, 8'h7F, "R10 prog over erase");
    op_done = 1; pulse();
    rd(sa(6, 0), 8'hFF, 8'hFF, "R10 back idle");

    // sector erase of sector 3
    addr = sa(3, 17); sec_erase_req = 1; pulse();
    rd(sa(3, 0), 8'hFF, 8'h7F, "R4 wait target");
    rd(sa(5, 0), 8'hFF, 8'h7F, "R4 wait other");
    susp_req = 1; pulse();
    rd(sa(3, 0), 8'hFF, 8'h7F, "R4 suspend ignored in wait");
    erase_go = 1; pulse();
    rd(sa(3, 1), 8'hFF, 8'h7F, "R4 erasing target");
    susp_req = 1; pulse();
    rd(sa(3, 2), 8'h12, 8'h92, "R7 suspended target");
    rd(sa(5, 2), 8'h12, 8'h12, "R7 suspended other 0");
    rd(sa(5, 2), 8'h92, 8'h92, "R7 suspended other 1");
    op_done = 1; pulse();
    rd(sa(3, 2), 8'h12, 8'h92, "R7 done ignored in suspend");
    resume_req = 1; pulse();
    rd(sa(3, 2), 8'hFF, 8'h7F, "R7 resumed target");
    op_done = 1; susp_req = 1; pulse();
    rd(sa(3, 2), 8'hFF, 8'hFF, "R10 done over suspend erased");
    rd(sa(3, 2), 8'h55, 8'h55, "R6 idle after sector erase");

    // chip erase
    chip_erase_req = 1; pulse();
    rd(sa(0, 0), 8'hFF, 8'h7F, "R5 chip erase 0");
    rd(sa(15, 8), 8'hFF, 8'h7F, "R5 chip erase far");
    susp_req = 1; pulse();
    rd(sa(0, 0), 8'hFF, 8'h7F, "R5 suspend ignored");
    op_done = 1; pulse();
    rd(sa(0, 0), 8'hFF, 8'hFF, "R6 chip erase done");

    // program failure
    wr_d7 = 1; prog_start = 1; pulse();
    op_fail = 1; pulse();
    rd(sa(1, 0), 8'hFF, 8'h7F, "R8 program fail hold");
    op_done = 1; pulse();
    rd(sa(1, 0), 8'hFF, 8'h7F, "R8 done ignored in fail");
    wr_d7 = 0; prog_start = 1; pulse();
    rd(sa(1, 0), 8'hFF, 8'h7F, "R8 start ignored in fail");
    clr = 1; pulse();
    rd(sa(1, 0), 8'hFF, 8'hFF, "R8 clr to idle");

    // erase failure with done in the same cycle
    addr = sa(1, 0); sec_erase_req = 1; pulse();
    erase_go = 1; pulse();
    op_fail = 1; op_done = 1; pulse();
    rd(sa(1, 0), 8'hFF, 8'h7F, "R10 fail over done");
    susp_req = 1; pulse();
    rd(sa(1, 0), 8'hFF, 8'h7F, "R8 erase fail holds 0");
    clr = 1; pulse();
    rd(sa(1, 0), 8'hFF, 8'hFF, "R8 clr after erase fail");

    // failure during the wait phase
    addr = sa(2, 0); sec_erase_req = 1; pulse();
    op_fail = 1; pulse();
    rd(sa(9, 0), 8'hFF, 8'h7F, "R8 fail in wait");
    clr = 1; pulse();
    rd(sa(9, 0), 8'hC3, 8'hC3, "R1 idle again");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule